// File: doc/BRIEF.md
# Quadword-to-Longword Bus Cycle Splitter

This block sits between a processor with a 64-bit data bus and a backplane whose data path is 32 bits wide. It carries out each 8-byte processor transfer as two 32-bit backplane subcycles, lower longword first, and holds the processor's ready line low until the last subcycle has been acknowledged. The second subcycle uses the original address plus 4. A half whose four byte enables are all inactive is skipped. A processor line burst of four 8-byte beats becomes eight 32-bit block stages, and ready is returned once per beat.

Each subcycle follows a fixed order of events. The address is presented one cycle ahead of the address strobe. The strobe and the per-lane data strobes are then raised, and the block waits for the slave's acknowledge. It drops the strobes and waits for the acknowledge to be released before it starts the next subcycle. For reads, the lower longword is held in a register and handed to the processor together with the upper one on the final acknowledge. A lane select output tells the external data buffer multiplexer which half of the 64-bit bus is connected to the backplane.

Top module: `qword_splitter`

## Requirements
- R1: After reset, bk_as, bk_ds, bk_write and cpu_rdy are all 0.
- R2: A single transfer with both halves enabled makes two subcycles: the first at base = {cpu_qaddr, 3'b000} with bk_lane = 0, the second at base + 4 with bk_lane = 1, so bk_addr[2] is 1 whenever bk_lane is 1 under the strobe.
- R3: Each subcycle takes exactly one bk_ack. bk_as falls in the cycle after bk_ack is seen, and no new subcycle starts until bk_ack is 0 again. cpu_rdy is a one-cycle pulse that is raised only while the final subcycle of a beat is being acknowledged.
- R4: In a single transfer, a half whose byte enables (cpu_be[3:0] for the lower half, cpu_be[7:4] for the upper half) are all 0 gets no subcycle. If all eight enables are 0, no subcycle runs and cpu_rdy pulses in the second cycle after the start.
- R5: The modifier bk_mod is 0x0D for a single data transfer, 0x0E for a single transfer with cpu_code = 1, and 0x0F for a block transfer.
- R6: A block transfer (cpu_block = 1) makes eight subcycles at base + 4*k for k = 0..7, with bk_lane = k[0] and all four data strobes active. The byte enables are ignored, and cpu_rdy pulses after every odd stage, four times in all.
- R7: During a read cpu_rdy, cpu_rdata = {upper word, lower word}, and the word of a skipped half reads 0. At every other time, and for writes, cpu_rdata is 0.
- R8: bk_ds bit i (i = 0..3) is the byte enable of lane i of the current half (cpu_be[i] for the lower half, cpu_be[4+i] for the upper half) and is active only while bk_as is 1. bk_write holds cpu_write for the whole transfer.
- R9: A cpu_start while a transfer is in progress is ignored and produces no subcycle.
- R10: bk_addr holds the same value in the cycle before bk_as rises as in the cycle in which it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_start | input | 1 | One-cycle request for a new transfer |
| cpu_qaddr | input | ADDR_W-3 | 8-byte-aligned processor address |
| cpu_be | input | 8 | Processor byte enables, bit i = byte i |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_block | input | 1 | 1 = line burst of BEATS beats |
| cpu_code | input | 1 | 1 = code fetch (single transfers) |
| cpu_rdy | output | 1 | Ready pulse, one per 8-byte beat |
| cpu_rdata | output | 2*HALF_W | Assembled read data, valid with cpu_rdy |
| bk_addr | output | ADDR_W | Backplane address |
| bk_as | output | 1 | Backplane address strobe |
| bk_ds | output | 4 | Per-lane data strobes |
| bk_write | output | 1 | Backplane write direction |
| bk_mod | output | 6 | Address modifier code |
| bk_lane | output | 1 | Data buffer multiplexer select, 0 = lower half |
| bk_ack | input | 1 | Slave data acknowledge |
| bk_rdata | input | HALF_W | Backplane read data |

## Verification
The assertions check the per-cycle handshake rules on every cycle. The address stays stable in the cycle the strobe rises. The strobe drops after an acknowledge, and ready is never longer than one cycle. An odd lane always carries an address with bit 2 set, the modifier stays in its three legal codes, a start during a transfer leaves the captured enables untouched, and a block finishes after exactly eight acknowledges. Other behaviours can only be shown by the bench's scenarios against its own model, running with a slave that varies its acknowledge delay and release time: the order and the address of the subcycles for each enable pattern, the skipping of empty halves, the null transfer, the assembled read data, and the absence of any subcycle for a start given during a transfer.

// File: rtl/csplit_pkg.sv
package csplit_pkg;

  localparam int HALF_LANES = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_STRB = 3'd2,
    ST_REL  = 3'd3,
    ST_NULL = 3'd4
  } split_state_t;

  localparam logic [5:0] AM_DATA  = 6'h0D;
  localparam logic [5:0] AM_CODE  = 6'h0E;
  localparam logic [5:0] AM_BLOCK = 6'h0F;

  function automatic logic [5:0] pick_mod(input logic block, input logic code);
    if (block) return AM_BLOCK;
    if (code) return AM_CODE;
    return AM_DATA;
  endfunction

  function automatic logic [HALF_LANES-1:0] half_enables(
    input logic [2*HALF_LANES-1:0] be, input logic upper);
    return upper ? be[2*HALF_LANES-1:HALF_LANES] : be[HALF_LANES-1:0];
  endfunction

endpackage

// File: rtl/csplit_seq.sv
module csplit_seq
  import csplit_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int STG_W = $clog2(2*BEATS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_start,
  input  logic [2*HALF_LANES-1:0] op_be,
  input  logic                    op_block,
  input  logic                    bk_ack,
  output logic [STG_W-1:0]        stage_o,
  output logic                    accept_o,
  output logic                    block_o,
  output logic                    strobe_o,
  output logic [HALF_LANES-1:0]   lanes_o,
  output logic                    word_ack_o,
  output logic                    rdy_o
);

  localparam int STAGES = 2*BEATS;
  localparam logic [STG_W-1:0] LAST_BLOCK = STG_W'(STAGES-1);

  split_state_t            state_q, state_d;
  logic [STG_W-1:0]        stage_q, stage_d;
  logic [2*HALF_LANES-1:0] be_q;
  logic                    block_q;
  logic                    fin_q;

  logic             last_stage;
  logic             beat_end;
  logic [STG_W-1:0] next_stage;

  assign last_stage = block_q ? (stage_q == LAST_BLOCK)
                              : (stage_q[0] || (half_enables(be_q, 1'b1) == '0));
  assign beat_end   = block_q ? stage_q[0] : last_stage;
  assign next_stage = block_q ? stage_q + 1'b1 : STG_W'(1);

  assign accept_o   = (state_q == ST_IDLE) && op_start;
  assign strobe_o   = (state_q == ST_STRB);
  assign word_ack_o = strobe_o && bk_ack;
  assign rdy_o      = (word_ack_o && beat_end) || (state_q == ST_NULL);
  assign lanes_o    = !strobe_o ? '0 : (block_q ? '1 : half_enables(be_q, stage_q[0]));
  assign stage_o    = stage_q;
  assign block_o    = block_q;

  always_comb begin
    state_d = state_q;
    stage_d = stage_q;
    case (state_q)
      ST_IDLE: if (op_start) begin
        stage_d = (op_block || (half_enables(op_be, 1'b0) != '0)) ? '0 : STG_W'(1);
        state_d = (!op_block && (op_be == '0)) ? ST_NULL : ST_ADDR;
      end
      ST_ADDR: state_d = ST_STRB;
      ST_STRB: if (bk_ack) state_d = ST_REL;
      ST_REL: if (!bk_ack) begin
        if (fin_q) state_d = ST_IDLE;
        else begin
          state_d = ST_ADDR;
          stage_d = next_stage;
        end
      end
      ST_NULL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stage_q <= '0;
      be_q    <= '0;
      block_q <= 1'b0;
      fin_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      stage_q <= stage_d;
      if (accept_o) begin
        be_q    <= op_be;
        block_q <= op_block;
        fin_q   <= 1'b0;
      end else if (word_ack_o) begin
        fin_q <= last_stage;
      end
    end
  end

  // Acknowledge counter kept only for the block-length check.
  logic [STG_W:0] ack_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) ack_cnt <= '0;
    else if (accept_o) ack_cnt <= '0;
    else if (word_ack_o) ack_cnt <= ack_cnt + 1'b1;
  end

  assert_as_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o && bk_ack) |=> !strobe_o);

  assert_rdy_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |=> !rdy_o);

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_IDLE) && op_start) |=> (be_q == $past(be_q)));

  assert_block_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_REL) && fin_q && !bk_ack && block_q) |-> (ack_cnt == (STG_W+1)'(STAGES)));

endmodule

// File: rtl/csplit_addrgen.sv
module csplit_addrgen #(
  parameter int ADDR_W = 32,
  parameter int STG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:3] qaddr,
  input  logic [STG_W-1:0]  stage,
  output logic [ADDR_W-1:0] addr_o
);

  function automatic logic [ADDR_W-1:0] sub_addr(
    input logic [ADDR_W-4:0] q, input logic [STG_W-1:0] s);
    return {q, 3'b000} + (ADDR_W'(s) << 2);
  endfunction

  logic [ADDR_W-4:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else if (load) base_q <= qaddr;
  end

  assign addr_o = sub_addr(base_q, stage);

endmodule

// File: rtl/csplit_rdlatch.sv
module csplit_rdlatch #(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                cap_lo,
  input  logic                present,
  input  logic                upper,
  input  logic [HALF_W-1:0]   word_in,
  output logic [2*HALF_W-1:0] rdata_o
);

  function automatic logic [2*HALF_W-1:0] assemble(
    input logic up, input logic [HALF_W-1:0] held, input logic [HALF_W-1:0] live);
    return up ? {live, held} : {{HALF_W{1'b0}}, live};
  endfunction

  logic [HALF_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lo_q <= '0;
    else if (clear) lo_q <= '0;
    else if (cap_lo) lo_q <= word_in;
  end

  assign rdata_o = present ? assemble(upper, lo_q, word_in) : '0;

endmodule

// File: rtl/qword_splitter.sv
module qword_splitter
  import csplit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int HALF_W = 32,
  parameter int BEATS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_start,
  input  logic [ADDR_W-1:3]       cpu_qaddr,
  input  logic [2*HALF_LANES-1:0] cpu_be,
  input  logic                    cpu_write,
  input  logic                    cpu_block,
  input  logic                    cpu_code,
  output logic                    cpu_rdy,
  output logic [2*HALF_W-1:0]     cpu_rdata,
  output logic [ADDR_W-1:0]       bk_addr,
  output logic                    bk_as,
  output logic [HALF_LANES-1:0]   bk_ds,
  output logic                    bk_write,
  output logic [5:0]              bk_mod,
  output logic                    bk_lane,
  input  logic                    bk_ack,
  input  logic [HALF_W-1:0]       bk_rdata
);

  localparam int STG_W = $clog2(2*BEATS);

  logic [STG_W-1:0] stage;
  logic             accept;
  logic             block_q;
  logic             word_ack;
  logic             wr_q;
  logic             code_q;

  csplit_seq #(.BEATS(BEATS), .STG_W(STG_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_start   (cpu_start),
    .op_be      (cpu_be),
    .op_block   (cpu_block),
    .bk_ack     (bk_ack),
    .stage_o    (stage),
    .accept_o   (accept),
    .block_o    (block_q),
    .strobe_o   (bk_as),
    .lanes_o    (bk_ds),
    .word_ack_o (word_ack),
    .rdy_o      (cpu_rdy)
  );

  csplit_addrgen #(.ADDR_W(ADDR_W), .STG_W(STG_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .qaddr  (cpu_qaddr),
    .stage  (stage),
    .addr_o (bk_addr)
  );

  csplit_rdlatch #(.HALF_W(HALF_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .cap_lo  (word_ack && !stage[0]),
    .present (cpu_rdy && word_ack && !wr_q),
    .upper   (stage[0]),
    .word_in (bk_rdata),
    .rdata_o (cpu_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      code_q <= 1'b0;
    end else if (accept) begin
      wr_q   <= cpu_write;
      code_q <= cpu_code;
    end
  end

  assign bk_write = wr_q;
  assign bk_mod   = pick_mod(block_q, code_q);
  assign bk_lane  = stage[0];

  assert_addr_setup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bk_as) |-> $stable(bk_addr));

  assert_odd_lane_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_as && bk_lane) |-> bk_addr[2]);

  assert_mod_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bk_as |-> ((bk_mod == AM_DATA) || (bk_mod == AM_CODE) || (bk_mod == AM_BLOCK)));

endmodule

// File: tb/qword_splitter_tb.sv
module qword_splitter_tb;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  ds;
    logic [5:0]  mod;
    logic        wr;
    logic        lane;
  } sub_t;

  typedef struct packed {
    logic [31:0] subs;
    logic [63:0] data;
  } rdy_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_start = 1'b0;
  logic [31:3] cpu_qaddr = '0;
  logic [7:0]  cpu_be = '0;
  logic        cpu_write = 1'b0;
  logic        cpu_block = 1'b0;
  logic        cpu_code = 1'b0;
  logic        cpu_rdy;
  logic [63:0] cpu_rdata;
  logic [31:0] bk_addr;
  logic        bk_as;
  logic [3:0]  bk_ds;
  logic        bk_write;
  logic [5:0]  bk_mod;
  logic        bk_lane;
  logic        bk_ack;
  logic [31:0] bk_rdata;

  always #5 clk = ~clk;

  qword_splitter u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_start(cpu_start), .cpu_qaddr(cpu_qaddr),
    .cpu_be(cpu_be), .cpu_write(cpu_write), .cpu_block(cpu_block), .cpu_code(cpu_code),
    .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata), .bk_addr(bk_addr), .bk_as(bk_as),
    .bk_ds(bk_ds), .bk_write(bk_write), .bk_mod(bk_mod), .bk_lane(bk_lane),
    .bk_ack(bk_ack), .bk_rdata(bk_rdata)
  );

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return {~a[15:0], a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  // Expected traffic, filled by the stimulus and consumed by the monitor.
  sub_t sub_q [0:127];
  rdy_t rdy_q [0:63];
  int   sub_wr = 0;
  int   rdy_wr = 0;
  int   sub_rd = 0;
  int   rdy_rd = 0;

  int init_checks = 0, init_errs = 0;
  int mon_checks = 0, mon_errs = 0;
  int cyc = 0;
  bit timed_out = 1'b0;

  // Slave model: acknowledge delay and release time vary per subcycle.
  logic        ack_r = 1'b0;
  logic [31:0] rdat_r = '0;
  int          nacks = 0, wcnt = 0, hcnt = 0;
  assign bk_ack   = ack_r;
  assign bk_rdata = rdat_r;

  always @(posedge clk) begin
    if (!rst_n) begin
      ack_r <= 1'b0; wcnt <= 0; hcnt <= 0; nacks <= 0;
    end else if (bk_as && !ack_r) begin
      if (wcnt >= nacks % 3) begin
        ack_r <= 1'b1; rdat_r <= word_of(bk_addr); wcnt <= 0;
      end else wcnt <= wcnt + 1;
    end else if (!bk_as && ack_r) begin
      if (hcnt >= nacks % 2) begin
        ack_r <= 1'b0; hcnt <= 0; nacks <= nacks + 1;
      end else hcnt <= hcnt + 1;
    end
  end

  task automatic mchk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    mon_checks++;
    if (!ok) begin
      mon_errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ichk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    init_checks++;
    if (!ok) begin
      init_errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares against the expected traffic on every clock.
  logic        as_prev = 1'b0, rdy_prev = 1'b0;
  logic [31:0] addr_prev = '0;
  always @(negedge clk) begin
    sub_t e;
    rdy_t r;
    cyc++;
    if (rst_n) begin
      if (bk_ds != 4'h0 && !bk_as) mchk(1'b0, "R8 strobes outside AS", 64'(bk_ds), 64'h0);
      if (cpu_rdy && rdy_prev) mchk(1'b0, "R3 ready wider than one cycle", 64'h1, 64'h0);
      if (bk_as && !as_prev) begin
        if (sub_rd == sub_wr) mchk(1'b0, "R9 unexpected subcycle", 64'(bk_addr), 64'h0);
        else begin
          e = sub_q[sub_rd];
          sub_rd++;
          mchk(bk_addr == e.addr, "R2 R6 subcycle address", 64'(bk_addr), 64'(e.addr));
          mchk(bk_lane == e.lane, "R2 lane select", 64'(bk_lane), 64'(e.lane));
          mchk(bk_ds == e.ds, "R8 data strobes", 64'(bk_ds), 64'(e.ds));
          mchk(bk_mod == e.mod, "R5 modifier", 64'(bk_mod), 64'(e.mod));
          mchk(bk_write == e.wr, "R8 write direction", 64'(bk_write), 64'(e.wr));
          mchk(bk_addr == addr_prev, "R10 address setup", 64'(bk_addr), 64'(addr_prev));
          mchk(!bk_ack, "R3 ack released before new subcycle", 64'(bk_ack), 64'h0);
        end
      end
      if (cpu_rdy) begin
        if (rdy_rd == rdy_wr) mchk(1'b0, "R3 unexpected ready", 64'h1, 64'h0);
        else begin
          r = rdy_q[rdy_rd];
          rdy_rd++;
          mchk(32'(sub_rd) == r.subs, "R3 R4 ready after final subcycle", 64'(sub_rd), 64'(r.subs));
          mchk(cpu_rdata == r.data, "R7 read data", cpu_rdata, r.data);
        end
      end else if (cpu_rdata != 64'h0) begin
        mchk(1'b0, "R7 read data outside ready", cpu_rdata, 64'h0);
      end
    end
    as_prev   = bk_as;
    addr_prev = bk_addr;
    rdy_prev  = cpu_rdy;
  end

  task automatic push_sub(input logic [31:0] a, input logic [3:0] ds, input logic [5:0] m,
                          input logic w, input logic lane);
    sub_q[sub_wr] = '{addr: a, ds: ds, mod: m, wr: w, lane: lane};
    sub_wr++;
  endtask

  task automatic push_rdy(input logic [63:0] d);
    rdy_q[rdy_wr] = '{subs: 32'(sub_wr), data: d};
    rdy_wr++;
  endtask

  task automatic issue(input logic [31:3] qa, input logic [7:0] be, input logic w,
                       input logic blk, input logic code, input bit ghost);
    logic [31:0] base;
    logic [5:0]  m;
    base = {qa, 3'b000};
    m = blk ? 6'h0F : (code ? 6'h0E : 6'h0D);
    if (blk) begin
      for (int b = 0; b < 4; b++) begin
        push_sub(base + 32'(8*b), 4'hF, m, w, 1'b0);
        push_sub(base + 32'(8*b + 4), 4'hF, m, w, 1'b1);
        push_rdy(w ? 64'h0 : {word_of(base + 32'(8*b + 4)), word_of(base + 32'(8*b))});
      end
    end else begin
      if (be[3:0] != 4'h0) push_sub(base, be[3:0], m, w, 1'b0);
      if (be[7:4] != 4'h0) push_sub(base + 32'd4, be[7:4], m, w, 1'b1);
      push_rdy((w || be == 8'h0) ? 64'h0 :
               {(be[7:4] != 4'h0) ? word_of(base + 32'd4) : 32'h0,
                (be[3:0] != 4'h0) ? word_of(base) : 32'h0});
    end
    @(negedge clk);
    cpu_qaddr = qa; cpu_be = be; cpu_write = w; cpu_block = blk; cpu_code = code;
    cpu_start = 1'b1;
    @(negedge clk);
    cpu_start = 1'b0;
    if (ghost) begin
      // R9: a second request while the first transfer is still running
      @(negedge clk);
      cpu_qaddr = qa ^ 29'h0F0F; cpu_be = 8'hFF; cpu_block = 1'b1;
      cpu_start = 1'b1;
      @(negedge clk);
      cpu_start = 1'b0;
    end
    while (rdy_rd != rdy_wr) @(negedge clk);
    repeat (3) @(negedge clk);
    ichk(sub_rd == sub_wr, "R3 R4 all expected subcycles seen", 64'(sub_rd), 64'(sub_wr));
  endtask

  task automatic run_all();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    ichk(bk_as == 1'b0, "R1 bk_as after reset", 64'(bk_as), 64'h0);
    ichk(bk_ds == 4'h0, "R1 bk_ds after reset", 64'(bk_ds), 64'h0);
    ichk(bk_write == 1'b0, "R1 bk_write after reset", 64'(bk_write), 64'h0);
    ichk(cpu_rdy == 1'b0, "R1 cpu_rdy after reset", 64'(cpu_rdy), 64'h0);
    issue(29'h0000_1234, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0); // R2 R7 full read
    issue(29'h0000_2001, 8'h0F, 1'b1, 1'b0, 1'b0, 1'b0); // R4 lower-only write
    issue(29'h0100_0077, 8'hF0, 1'b0, 1'b0, 1'b1, 1'b0); // R4 R5 upper-only code read
    issue(29'h0000_0ABC, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0); // R8 partial enables
    issue(29'h0000_0ABD, 8'h81, 1'b0, 1'b0, 1'b0, 1'b0); // R7 R8 sparse read
    issue(29'h0000_0555, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0); // R4 null transfer
    issue(29'h0000_4000, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0); // R6 block read
    issue(29'h0000_8010, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0); // R6 block write, enables ignored
    issue(29'h0000_3333, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1); // R9 start while busy
    repeat (10) @(negedge clk);
    ichk(sub_rd == sub_wr, "R9 no extra subcycle after ignored start", 64'(sub_rd), 64'(sub_wr));
    ichk(bk_as == 1'b0, "R9 idle after ignored start", 64'(bk_as), 64'h0);
  endtask

  initial begin
    fork
      run_all();
      begin
        wait (cyc >= 20000);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      init_checks++;
      init_errs++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors",
             init_checks + mon_checks, init_errs + mon_errs);
    $finish;
  end

endmodule